// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block holds the single reservation that one hart keeps for a load-reserved / store-conditional atomic pair. The pipeline reports every retiring instruction to it as a class code and an address. It also reports trap entry. A load-reserved records a reservation on the 64-byte granule that holds its address. A later store-conditional is either allowed to write or refused, in the same cycle it is presented. The block returns the code the store-conditional writes to its destination: 0 for success, 1 for failure.

A snoop port carries stores made by other agents. A snooped store that lands in the reserved granule cancels the reservation. The reservation is also cancelled by trap entry, by any exception-return (whatever its privilege level, and whatever mode executes it), and by the store-conditional itself.

Alongside the reservation, a flag reports whether the sequence in progress still qualifies for the guarantee of eventual success. The flag drops when:
- more than sixteen instructions retire after the load-reserved, or
- a system, floating-point or multiply/divide instruction retires inside the sequence.

Top module: `lrsc_monitor`

## Requirements
- R1: After a synchronous reset, `resv_valid` and `in_window` are both 0.
- R2: A retiring instruction of class 1 (load-reserved) sets `resv_valid` and `in_window` on the next edge. It records the address, replacing any earlier reservation, and restarts the instruction count. Class 0 is an ordinary instruction.
- R3: A retiring class 2 instruction (store-conditional) raises `sc_grant` in the same cycle only if a reservation is valid and the address matches the reserved address in bits [ADDR_W-1:6]. `sc_code` is 0 when the store is granted and 1 when it is refused.
- R4: Every store-conditional clears `resv_valid` and `in_window` on the next edge, whether it succeeds or fails.
- R5: A retiring class 6 instruction (exception-return of any privilege level) clears the reservation and `in_window`, so a later store-conditional fails.
- R6: `trap_taken` clears the reservation and `in_window`. While `trap_taken` is high, a retiring instruction is discarded, so a store-conditional in that cycle fails.
- R7: A snooped store (`snoop_valid`) into the reserved granule clears the reservation. A store-conditional in the same cycle fails. A snoop outside the granule has no effect.
- R8: Sixteen instructions retiring between a load-reserved and its store-conditional keep `in_window` high. The seventeenth clears it, and the reservation stays valid.
- R9: A retiring class 3 (system), 4 (floating-point) or 5 (multiply/divide) instruction clears `in_window` but leaves the reservation valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_class | input | 3 | Class code of the retiring instruction |
| ret_addr | input | ADDR_W | Memory address of the retiring LR/SC |
| trap_taken | input | 1 | Trap entry this cycle |
| snoop_valid | input | 1 | Another agent's store is observed |
| snoop_addr | input | ADDR_W | Address of the observed store |
| sc_grant | output | 1 | Store-conditional may write (combinational) |
| sc_code | output | 1 | Destination value of the store-conditional |
| resv_valid | output | 1 | A reservation is held |
| in_window | output | 1 | Sequence still within the forward-progress limits |

## Verification
Store-conditionals are presented in the same granule as the reservation, in a neighbouring granule, with no reservation held, and after the reservation has been replaced. These cases separate a match on the granule from a match on the whole address, and separate the latest reservation from a stale one.

Each cancelling event comes in its own sequence: exception-return, trap, snoop hit, and a snoop in the same cycle as the store. A snoop miss shows that only stores into the reserved granule count.

The instruction count is tried at exactly sixteen and at seventeen intervening instructions, which exposes an off-by-one in the limit. Each disqualifying class is tried alone to show that it drops the flag and leaves the reservation held.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [2:0] {
        CL_OTHER  = 3'd0,
        CL_LR     = 3'd1,
        CL_SC     = 3'd2,
        CL_SYSTEM = 3'd3,
        CL_FP     = 3'd4,
        CL_MULDIV = 3'd5,
        CL_XRET   = 3'd6
    } ret_cls_e;

    typedef struct packed {
        logic     lr;
        logic     sc;
        logic     xret;
        logic     disq;
        logic     counted;
    } ret_ev_t;

    function automatic ret_ev_t decode_ret(input logic valid, input ret_cls_e cls);
        ret_ev_t ev;
        ev.lr      = valid && (cls == CL_LR);
        ev.sc      = valid && (cls == CL_SC);
        ev.xret    = valid && (cls == CL_XRET);
        ev.disq    = valid && (cls == CL_SYSTEM || cls == CL_FP ||
                               cls == CL_MULDIV || cls == CL_XRET);
        ev.counted = valid && (cls != CL_LR) && (cls != CL_SC);
        return ev;
    endfunction

endpackage

// File: rtl/lrsc_granule_cmp.sv
module lrsc_granule_cmp #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 6
) (
    input  logic [ADDR_W-GRAN_LG2-1:0] held,
    input  logic [ADDR_W-1:0]          probe,
    output logic                       hit
);
    always_comb hit = (probe[ADDR_W-1:GRAN_LG2] == held);
endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clear,
    output logic             valid,
    output logic [TAG_W-1:0] tag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            tag   <= '0;
        end else if (set) begin
            valid <= 1'b1;
            tag   <= set_tag;
        end else if (clear) begin
            valid <= 1'b0;
        end
    end

    a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
        set |=> (valid && tag == $past(set_tag)));
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clear && !set) |=> !valid);
endmodule

// File: rtl/lrsc_window_ctr.sv
module lrsc_window_ctr #(
    parameter int WINDOW_MAX = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic count_en,
    input  logic disq,
    output logic in_window
);
    localparam int CNT_W = $clog2(WINDOW_MAX + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW_MAX);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            in_window <= 1'b0;
        end else if (start) begin
            cnt       <= '0;
            in_window <= 1'b1;
        end else if (stop || disq) begin
            in_window <= 1'b0;
        end else if (count_en && in_window) begin
            if (cnt == LIMIT) in_window <= 1'b0;
            else              cnt <= cnt + 1'b1;
        end
    end

    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        in_window |-> (cnt <= LIMIT));
    a_r9_disq_drops: assert property (@(posedge clk) disable iff (rst)
        (disq && !start) |=> !in_window);
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int GRAN_LG2   = 6,
    parameter int WINDOW_MAX = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ret_valid,
    input  logic [2:0]        ret_class,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              trap_taken,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              sc_grant,
    output logic              sc_code,
    output logic              resv_valid,
    output logic              in_window
);
    localparam int TAG_W = ADDR_W - GRAN_LG2;

    ret_ev_t          ev;
    logic [TAG_W-1:0] resv_tag;
    logic             sc_match;
    logic             snoop_match;
    logic             snoop_hit;
    logic             kill;

    // A trap discards the instruction presented with it.
    always_comb ev = decode_ret(ret_valid && !trap_taken, ret_cls_e'(ret_class));

    lrsc_granule_cmp #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_sc_cmp (
        .held(resv_tag), .probe(ret_addr), .hit(sc_match));

    lrsc_granule_cmp #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_snoop_cmp (
        .held(resv_tag), .probe(snoop_addr), .hit(snoop_match));

    always_comb begin
        snoop_hit = snoop_valid && resv_valid && snoop_match;
        sc_grant  = ev.sc && resv_valid && sc_match && !snoop_hit;
        sc_code   = !sc_grant;
        kill      = trap_taken || ev.xret || ev.sc || snoop_hit;
    end

    lrsc_resv_reg #(.TAG_W(TAG_W)) u_resv (
        .clk(clk), .rst(rst),
        .set(ev.lr), .set_tag(ret_addr[ADDR_W-1:GRAN_LG2]),
        .clear(kill),
        .valid(resv_valid), .tag(resv_tag));

    lrsc_window_ctr #(.WINDOW_MAX(WINDOW_MAX)) u_win (
        .clk(clk), .rst(rst),
        .start(ev.lr), .stop(kill),
        .count_en(ev.counted), .disq(ev.disq),
        .in_window(in_window));

    a_r3_grant_needs_resv: assert property (@(posedge clk) disable iff (rst)
        sc_grant |-> resv_valid);
    a_r4_sc_clears: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !trap_taken && ret_class == 3'd2) |=> (!resv_valid && !in_window));
    a_r5_xret_clears: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !trap_taken && ret_class == 3'd6) |=> !resv_valid);
    a_r6_trap_clears: assert property (@(posedge clk) disable iff (rst)
        trap_taken |=> (!resv_valid && !in_window));
    a_r6_trap_no_grant: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> !sc_grant);
    a_r2_lr_opens: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !trap_taken && ret_class == 3'd1) |=> (resv_valid && in_window));
    a_r8_window_implies_resv: assert property (@(posedge clk) disable iff (rst)
        in_window |-> resv_valid);
endmodule

// File: tb/tb_lrsc_monitor.sv
module tb_lrsc_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          ret_valid;
    logic [2:0]    ret_class;
    logic [AW-1:0] ret_addr;
    logic          trap_taken;
    logic          snoop_valid;
    logic [AW-1:0] snoop_addr;
    logic          sc_grant, sc_code, resv_valid, in_window;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lrsc_monitor dut (
        .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_class(ret_class),
        .ret_addr(ret_addr), .trap_taken(trap_taken), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .sc_grant(sc_grant), .sc_code(sc_code),
        .resv_valid(resv_valid), .in_window(in_window));

    typedef struct packed {
        logic          rv;
        logic [2:0]    cls;
        logic [AW-1:0] addr;
        logic          trap;
        logic          sv;
        logic [AW-1:0] saddr;
        logic          eg;
        logic          er;
        logic          ew;
    } vec_t;

    localparam int NV = 22;
    // class codes: 0 other, 1 LR, 2 SC, 3 system, 4 FP, 5 muldiv, 6 xret
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd1, 32'h1000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1}, // R2
        '{1'b1, 3'd0, 32'h0,    1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1}, // R2
        '{1'b1, 3'd2, 32'h1020, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0}, // R3 R4
        '{1'b1, 3'd2, 32'h1000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R3
        '{1'b1, 3'd1, 32'h2000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1},
        '{1'b1, 3'd2, 32'h2040, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R3 R4
        '{1'b1, 3'd1, 32'h3000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1},
        '{1'b1, 3'd6, 32'h0,    1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R5
        '{1'b1, 3'd2, 32'h3000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R5
        '{1'b1, 3'd1, 32'h4000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1},
        '{1'b0, 3'd0, 32'h0,    1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R6
        '{1'b1, 3'd1, 32'h5000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1},
        '{1'b0, 3'd0, 32'h0,    1'b0, 1'b1, 32'h5010, 1'b0, 1'b0, 1'b0}, // R7
        '{1'b1, 3'd1, 32'h6000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1},
        '{1'b0, 3'd0, 32'h0,    1'b0, 1'b1, 32'h7000, 1'b0, 1'b1, 1'b1}, // R7 miss
        '{1'b1, 3'd2, 32'h6008, 1'b0, 1'b1, 32'h6030, 1'b0, 1'b0, 1'b0}, // R7 same cycle
        '{1'b1, 3'd1, 32'h8000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1},
        '{1'b1, 3'd1, 32'h9000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1}, // R2 replace
        '{1'b1, 3'd2, 32'h8000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R2 stale
        '{1'b1, 3'd1, 32'hA000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1},
        '{1'b1, 3'd5, 32'h0,    1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b0}, // R9
        '{1'b1, 3'd2, 32'hA000, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0}  // R9 R3
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, check the same-cycle grant, then the state after the edge.
    task automatic step(input logic rv, input logic [2:0] cls, input logic [AW-1:0] a,
                        input logic tr, input logic sv, input logic [AW-1:0] sa,
                        input logic eg, input logic er, input logic ew, input string req);
        @(negedge clk);
        ret_valid = rv; ret_class = cls; ret_addr = a;
        trap_taken = tr; snoop_valid = sv; snoop_addr = sa;
        #1;
        if (rv && cls == 3'd2) begin
            check(req, "sc_grant", sc_grant, eg);
            check(req, "sc_code", sc_code, !eg);
        end
        @(posedge clk); #1;
        ret_valid = 1'b0; trap_taken = 1'b0; snoop_valid = 1'b0;
        check(req, "resv_valid", resv_valid, er);
        check(req, "in_window", in_window, ew);
    endtask

    task automatic run_other(input int n, input logic ew_last, input string req);
        for (int i = 0; i < n; i++)
            step(1'b1, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1,
                 (i == n - 1) ? ew_last : 1'b1, req);
    endtask

    initial begin
        rst = 1'b1; ret_valid = 1'b0; ret_class = 3'd0; ret_addr = '0;
        trap_taken = 1'b0; snoop_valid = 1'b0; snoop_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "resv_valid", resv_valid, 1'b0);
        check("R1", "in_window", in_window, 1'b0);
        @(negedge clk); rst = 1'b0;

        for (int v = 0; v < NV; v++)
            step(VECS[v].rv, VECS[v].cls, VECS[v].addr, VECS[v].trap, VECS[v].sv,
                 VECS[v].saddr, VECS[v].eg, VECS[v].er, VECS[v].ew, $sformatf("vec%0d", v));

        // R8: sixteen intervening instructions stay in the window
        step(1'b1, 3'd1, 32'hB000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, "R8");
        run_other(16, 1'b1, "R8");
        step(1'b1, 3'd2, 32'hB03C, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R8");
        // R8: the seventeenth drops the flag, reservation kept
        step(1'b1, 3'd1, 32'hC000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, "R8");
        run_other(17, 1'b0, "R8");
        step(1'b1, 3'd2, 32'hC000, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R8");

        // R9: system and floating-point classes
        step(1'b1, 3'd1, 32'hD000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, "R9");
        step(1'b1, 3'd3, 32'h0,    1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b1, 3'd1, 32'hD000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, "R9");
        step(1'b1, 3'd4, 32'h0,    1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, "R9");

        // R6: store-conditional presented together with a trap
        step(1'b1, 3'd1, 32'hE000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, "R6");
        step(1'b1, 3'd2, 32'hE000, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, "R6");

        // R1: reset in the middle of a reservation
        step(1'b1, 3'd1, 32'hF000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, "R1");
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1", "resv_valid", resv_valid, 1'b0);
        check("R1", "in_window", in_window, 1'b0);
        @(negedge clk); rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule